// File: doc/BRIEF.md
# Double-Data-Rate Receive Nibble-to-Byte Rebuilder

This block sits right behind the receive pins of a reduced-width gigabit media interface. The PHY sends four data bits and one control line and drives its own receive clock. The clock runs at 125 MHz, 25 MHz or 2.5 MHz, depending on link speed. Data arrives on both clock edges. The block samples the pins on each edge and joins the two halves into one byte per clock. It also splits the shared control line into a separate data-valid flag and a separate error flag.

The rising-edge sample is held in a register until the falling-edge sample arrives. On the next rising edge, the full byte and both flags are loaded into the output registers in one step. A downstream byte-wide receive path in the same clock domain can then read a stream that looks like a classic eight-bit interface. Crossing into the MAC clock, trimming input delays, and parsing frames are left to other blocks.

Top module: `rgmii_rx_ddr`

## Requirements
- R1: `rst` is synchronous and active high. Any rising edge of `rx_clk` that samples `rst` high forces `gmii_d` to 0 and `gmii_dv` and `gmii_er` to 0.
- R2: The nibble on `rx_d` sampled at a rising edge of `rx_clk` appears on `gmii_d[3:0]`.
- R3: The nibble on `rx_d` sampled at the falling edge that follows that rising edge appears on `gmii_d[7:4]`.
- R4: `rx_ctl` sampled at the rising edge appears on `gmii_dv` (1 = byte valid).
- R5: `rx_ctl` sampled at the following falling edge appears on `gmii_er` (1 = error). This holds whether `gmii_dv` is 1 or 0, so an error seen with valid low is still reported.
- R6: Byte, valid and error change together at the rising edge that follows the rising-edge sample: a fixed latency of one clock.
- R7: Reset also clears both half-cycle holding registers. The first output after reset release is all zero, even if the pins were high during reset.
- R8: `gmii_d` carries the sampled nibbles every cycle, including cycles where `gmii_dv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY; both edges carry data |
| rst | input | 1 | Synchronous active-high reset |
| rx_d | input | 4 | Double-rate receive data nibble |
| rx_ctl | input | 1 | Shared control line: valid on the rising edge, error on the falling edge |
| gmii_d | output | 8 | Rebuilt byte: low nibble from the rising edge, high nibble from the falling edge |
| gmii_dv | output | 1 | Byte valid flag |
| gmii_er | output | 1 | Receive error flag |

## Verification
The bench sends asymmetric bytes such as A5, 5A, 0F and F0. A design that swapped the two nibbles, or paired a falling sample with the wrong rising sample, would return a mirrored byte or a byte split across two cycles. It sets the error flag both inside a valid burst and with valid low. A design that masked the error with valid, or took the error from the rising edge, would show a missing or wrongly placed error. Reset is asserted in the middle of a burst while the pins are held high. A design whose holding registers survive reset would emit a stale byte on the first cycle after release. Every byte is checked exactly one clock after its rising sample, so an extra or missing pipeline stage shows up at once.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;

    // Width of one pin-side half sample and of the rebuilt byte
    localparam int RX_NIB_W  = 4;
    localparam int RX_BYTE_W = 2 * RX_NIB_W;

    // One edge worth of pin state: control bit above the data nibble
    typedef struct packed {
        logic                ctl;
        logic [RX_NIB_W-1:0] nib;
    } rx_half_t;

    localparam int RX_HALF_W = $bits(rx_half_t);

endpackage

// File: rtl/rgmii_edge_reg.sv
// Single-edge capture register with synchronous reset.
// FALLING selects which clock edge loads the register.
module rgmii_edge_reg #(
    parameter int W       = 5,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rgmii_byte_merge.sv
// Joins the held rising-edge half and the falling-edge half into one
// registered byte with separate valid and error flags.
module rgmii_byte_merge
    import rgmii_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rx_half_t             lo_half,
    input  rx_half_t             hi_half,
    output logic [RX_BYTE_W-1:0] byte_q,
    output logic                 dv_q,
    output logic                 er_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            dv_q   <= 1'b0;
            er_q   <= 1'b0;
        end else begin
            byte_q <= {hi_half.nib, lo_half.nib};
            dv_q   <= lo_half.ctl;
            er_q   <= hi_half.ctl;
        end
    end

endmodule

// File: rtl/rgmii_rx_ddr.sv
// Double-rate receive capture: samples the pins on both edges of the
// PHY clock and presents one byte per cycle on the rising edge.
module rgmii_rx_ddr
    import rgmii_rx_pkg::*;
(
    input  logic                 rx_clk,
    input  logic                 rst,
    input  logic [RX_NIB_W-1:0]  rx_d,
    input  logic                 rx_ctl,
    output logic [RX_BYTE_W-1:0] gmii_d,
    output logic                 gmii_dv,
    output logic                 gmii_er
);

    rx_half_t pin_half;
    rx_half_t rise_half;
    rx_half_t fall_half;

    assign pin_half = '{ctl: rx_ctl, nib: rx_d};

    // Rising edge: low nibble and valid, held for the rest of the cycle
    rgmii_edge_reg #(
        .W       (RX_HALF_W),
        .FALLING (1'b0)
    ) u_rise_cap (
        .clk (rx_clk),
        .rst (rst),
        .d   (pin_half),
        .q   (rise_half)
    );

    // Falling edge: high nibble and error
    rgmii_edge_reg #(
        .W       (RX_HALF_W),
        .FALLING (1'b1)
    ) u_fall_cap (
        .clk (rx_clk),
        .rst (rst),
        .d   (pin_half),
        .q   (fall_half)
    );

    rgmii_byte_merge u_merge (
        .clk     (rx_clk),
        .rst     (rst),
        .lo_half (rise_half),
        .hi_half (fall_half),
        .byte_q  (gmii_d),
        .dv_q    (gmii_dv),
        .er_q    (gmii_er)
    );

endmodule

// File: rtl/rgmii_rx_ddr_chk.sv
// Port-level checker for rgmii_rx_ddr, attached with bind below.
module rgmii_rx_ddr_chk
    import rgmii_rx_pkg::*;
(
    input logic                 rx_clk,
    input logic                 rst,
    input logic [RX_NIB_W-1:0]  rx_d,
    input logic                 rx_ctl,
    input logic [RX_BYTE_W-1:0] gmii_d,
    input logic                 gmii_dv,
    input logic                 gmii_er
);

    // Cycles since reset release, saturating at 2
    logic [1:0]          warm;
    logic [RX_NIB_W-1:0] pin_fall_d;
    logic                pin_fall_ctl;

    always_ff @(posedge rx_clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    always_ff @(negedge rx_clk) begin
        pin_fall_d   <= rx_d;
        pin_fall_ctl <= rx_ctl;
    end

    a_r1_reset_clear: assert property (@(posedge rx_clk)
        $past(rst) |-> (gmii_d == '0 && !gmii_dv && !gmii_er));

    // R2 and R6: low nibble follows the rising sample one clock later
    a_r2_lo_nibble: assert property (@(posedge rx_clk) disable iff (rst)
        (warm == 2'd2) |-> (gmii_d[RX_NIB_W-1:0] == $past(rx_d, 2)));

    a_r3_hi_nibble: assert property (@(posedge rx_clk) disable iff (rst)
        (warm == 2'd2) |-> (gmii_d[RX_BYTE_W-1:RX_NIB_W] == $past(pin_fall_d)));

    a_r4_valid: assert property (@(posedge rx_clk) disable iff (rst)
        (warm == 2'd2) |-> (gmii_dv == $past(rx_ctl, 2)));

    a_r5_error: assert property (@(posedge rx_clk) disable iff (rst)
        (warm == 2'd2) |-> (gmii_er == $past(pin_fall_ctl)));

endmodule

bind rgmii_rx_ddr rgmii_rx_ddr_chk u_chk (
    .rx_clk  (rx_clk),
    .rst     (rst),
    .rx_d    (rx_d),
    .rx_ctl  (rx_ctl),
    .gmii_d  (gmii_d),
    .gmii_dv (gmii_dv),
    .gmii_er (gmii_er)
);

// File: tb/rgmii_rx_ddr_tb.sv
`timescale 1ns/1ps
module rgmii_rx_ddr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rx_d = 4'hF;
    logic       rx_ctl = 1'b1;
    logic [7:0] gmii_d;
    logic       gmii_dv;
    logic       gmii_er;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Expected output for the pair whose rising half was last driven
    logic [9:0] prev_exp = '0;
    string      prev_req = "";
    bit         prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    rgmii_rx_ddr u_dut (
        .rx_clk  (clk),
        .rst     (rst),
        .rx_d    (rx_d),
        .rx_ctl  (rx_ctl),
        .gmii_d  (gmii_d),
        .gmii_dv (gmii_dv),
        .gmii_er (gmii_er)
    );

    // Compare {dv, er, byte}
    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got dv=%b er=%b d=%h, expected dv=%b er=%b d=%h",
                     req, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
        end
    endtask

    // Drive one byte across a rising and a falling edge. The byte driven on
    // the previous call is checked one clock after its rising sample.
    task automatic drive_pair(input logic [7:0] b, input logic dv, input logic er,
                              input string req);
        @(negedge clk); #1;
        rx_d   = b[3:0];
        rx_ctl = dv;
        @(posedge clk); #1;
        if (prev_valid) check(prev_req, {gmii_dv, gmii_er, gmii_d}, prev_exp);
        rx_d   = b[7:4];
        rx_ctl = er;
        prev_exp   = {dv, er, b};
        prev_req   = req;
        prev_valid = 1'b1;
    endtask

    task automatic flush();
        drive_pair(8'h00, 1'b0, 1'b0, "R8 idle");
    endtask

    // R1 and R7: reset with the pins held high, then release
    task automatic t_reset();
        @(negedge clk); #1;
        rst        = 1'b1;
        rx_d       = 4'hF;
        rx_ctl     = 1'b1;
        prev_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset clears outputs", {gmii_dv, gmii_er, gmii_d}, 10'h000);
        @(negedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;
        check("R7 holding regs cleared", {gmii_dv, gmii_er, gmii_d}, 10'h000);
        // Pins stayed high across this edge and the next falling edge
        prev_exp   = {1'b1, 1'b1, 8'hFF};
        prev_req   = "R2 R3 first byte after release";
        prev_valid = 1'b1;
    endtask

    // R2, R3, R4, R6: valid burst with asymmetric nibbles
    task automatic t_frame();
        drive_pair(8'h55, 1'b1, 1'b0, "R4 burst 55");
        drive_pair(8'hD5, 1'b1, 1'b0, "R6 burst D5");
        drive_pair(8'hA5, 1'b1, 1'b0, "R2 R3 nibble order A5");
        drive_pair(8'h5A, 1'b1, 1'b0, "R2 R3 nibble order 5A");
        drive_pair(8'h0F, 1'b1, 1'b0, "R2 low nibble 0F");
        drive_pair(8'hF0, 1'b1, 1'b0, "R3 high nibble F0");
        drive_pair(8'h23, 1'b1, 1'b0, "R6 burst 23");
        flush();
    endtask

    // R8: data with valid low still reaches the byte output
    task automatic t_idle_data();
        drive_pair(8'h3C, 1'b0, 1'b0, "R8 data with valid low");
        drive_pair(8'hC3, 1'b0, 1'b0, "R8 data with valid low");
        flush();
    endtask

    // R5: error inside a burst and with valid low
    task automatic t_error();
        drive_pair(8'h77, 1'b1, 1'b0, "R4 before error");
        drive_pair(8'h88, 1'b1, 1'b1, "R5 error with valid");
        drive_pair(8'h00, 1'b0, 1'b1, "R5 error with valid low");
        drive_pair(8'h9E, 1'b0, 1'b1, "R5 error valid low data");
        flush();
    endtask

    // R7 mid-stream: reset lands while bytes are flowing
    task automatic t_reset_mid();
        drive_pair(8'hE1, 1'b1, 1'b0, "R4 pre reset");
        drive_pair(8'h1E, 1'b1, 1'b1, "R5 pre reset");
        t_reset();
        drive_pair(8'h42, 1'b1, 1'b0, "R2 after mid reset");
        flush();
    endtask

    initial begin
        t_reset();
        t_frame();
        t_idle_data();
        t_error();
        t_reset_mid();
        flush();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule